// File: doc/BRIEF.md
# Masked-Write PHY Configuration Bridge

This block sits between a host register interface and a small PHY configuration space. The host sees two 32-bit registers. The first is a writable command register. The second is a read-only status register. On every write to the command register, the upper sixteen bits of the written word act as a per-bit enable for the lower sixteen bits. Software can therefore change one field without a read-modify-write sequence.

The lower half of the command register packs three things: a configuration address, a configuration data nibble and a commit strobe. When the strobe goes from 0 to 1, the data nibble is stored into a 64-entry by 4-bit configuration array held inside the block. To read an entry, software points the address field at it and then reads the status register. The status register returns the addressed entry in its low nibble, together with two PLL indications taken from the PHY. Two entries of the array drive control outputs: bit 3 of entry 0x10 selects separate-rate clocking, and bit 3 of entry 0x12 selects a 100 MHz PLL reference.

Top module: `phycfg_bridge`

## Requirements
- R1: After a synchronous reset, the command register reads 0, every configuration entry is 0, and both `sep_rate` and `ref_100m` are 0.
- R2: On a command-register write, lower bit x (x = 0..15) takes bit x of the written word only when bit x+16 of that word is 1. All other lower bits keep their value. Bits 31:16 of the command register always read back as 0.
- R3: In the command register, bits 6:1 are the configuration address, bits 10:7 are the configuration data and bit 0 is the commit strobe. Bits 15:11 are plain storage bits that read back as written.
- R4: When bit 0 of the command register changes from 0 to 1, the data field is stored into the entry selected by the address field on the following clock edge.
- R5: A write that leaves the strobe at 1 commits nothing, and neither does a write whose bit-16 enable is 0. Only a fresh 0-to-1 change commits.
- R6: Status bits 3:0 return the entry selected by the current address field. Every status bit other than 3:0, 9 and 10 reads 0.
- R7: Status bit 9 follows the `pll_locked` input and status bit 10 follows the `pll_out_en` input in the same cycle.
- R8: `sep_rate` equals bit 3 of entry 0x10 and `ref_100m` equals bit 3 of entry 0x12.
- R9: A commit stores the address and data that were present when the strobe rose, even if another command write lands in the same cycle as the commit.
- R10: Register bus cycles with `bus_we` = 0, and writes directed at the status register (`bus_sel` = 1), change neither the command register nor any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write access |
| bus_sel | input | 1 | 0 = command register, 1 = status register |
| bus_wdata | input | 32 | Write word: bits 31:16 enable, bits 15:0 value |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| pll_locked | input | 1 | PLL lock indication from the PHY |
| pll_out_en | input | 1 | PLL output state from the PHY |
| sep_rate | output | 1 | Bit 3 of configuration entry 0x10 |
| ref_100m | output | 1 | Bit 3 of configuration entry 0x12 |

## Verification
Two events can fall in the same cycle: an entry commit and the next host write. The commit lands one edge after the strobe rises, and a back-to-back write can land on that same edge with a new address and new data. The bench provokes this by issuing two command writes on consecutive edges. It then reads both the first and the second address through the status register. The first address must hold the first data nibble, and the second address must be unchanged. A reference model of the masked merge and the rising-edge commit judges the long pseudo-random write sweep in the same way.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;

    localparam int REG_W      = 32;
    localparam int HALF_W     = REG_W / 2;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 4;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int STB_BIT    = 0;
    localparam int ADDR_LSB   = 1;
    localparam int DATA_LSB   = ADDR_LSB + ADDR_W;
    localparam int LOCK_BIT   = 9;
    localparam int PLLOUT_BIT = 10;
    localparam int CTRL_BIT   = 3;

    localparam logic [ADDR_W-1:0] CLKTEST_ADDR = 6'h10;
    localparam logic [ADDR_W-1:0] SCC_ADDR     = 6'h12;

    typedef enum logic {
        SEL_CMD  = 1'b0,
        SEL_STAT = 1'b1
    } bus_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cfg_cmd_t;

    function automatic logic [HALF_W-1:0] masked_merge(
        input logic [HALF_W-1:0] old_val,
        input logic [REG_W-1:0]  word
    );
        logic [HALF_W-1:0] en;
        en = word[REG_W-1:HALF_W];
        return (old_val & ~en) | (word[HALF_W-1:0] & en);
    endfunction

    function automatic cfg_cmd_t decode_cmd(input logic [HALF_W-1:0] r);
        cfg_cmd_t c;
        c.addr = r[ADDR_LSB +: ADDR_W];
        c.data = r[DATA_LSB +: DATA_W];
        return c;
    endfunction

endpackage

// File: rtl/phycfg_maskreg.sv
module phycfg_maskreg
    import phycfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [HALF_W-1:0] cfg_q,
    output cfg_cmd_t          cmd,
    output logic              commit
);

    logic strb_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            strb_d <= 1'b0;
        end else begin
            if (wr_en) begin
                cfg_q <= masked_merge(cfg_q, wdata);
            end
            strb_d <= cfg_q[STB_BIT];
        end
    end

    assign cmd    = decode_cmd(cfg_q);
    assign commit = cfg_q[STB_BIT] & ~strb_d;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (((cfg_q ^ $past(cfg_q)) & ~$past(wdata[REG_W-1:HALF_W])) == '0)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_q)); // R10
    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit); // R5
    AST_COMMIT_EDGE: assert property (@(posedge clk) disable iff (rst)
        commit |-> !$past(cfg_q[STB_BIT])); // R4

endmodule

// File: rtl/phycfg_array.sv
module phycfg_array #(
    parameter int AW     = 6,
    parameter int DW     = 4,
    parameter int TAP_A  = 16,
    parameter int TAP_B  = 18,
    parameter int TAP_BIT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          tap_a,
    output logic          tap_b
);

    localparam int NENT = 1 << AW;

    logic [DW-1:0] mem [NENT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NENT; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
    assign tap_a = mem[TAP_A][TAP_BIT];
    assign tap_b = mem[TAP_B][TAP_BIT];

    AST_STORE: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata))); // R4

endmodule

// File: rtl/phycfg_status.sv
module phycfg_status
    import phycfg_pkg::*;
(
    input  logic              sel,
    input  logic [HALF_W-1:0] cfg_q,
    input  logic [DATA_W-1:0] entry,
    input  logic              pll_locked,
    input  logic              pll_out_en,
    output logic [REG_W-1:0]  rdata
);

    always_comb begin
        rdata = '0;
        if (sel == SEL_STAT) begin
            rdata[DATA_W-1:0] = entry;
            rdata[LOCK_BIT]   = pll_locked;
            rdata[PLLOUT_BIT] = pll_out_en;
        end else begin
            rdata[HALF_W-1:0] = cfg_q;
        end
    end

endmodule

// File: rtl/phycfg_bridge.sv
module phycfg_bridge
    import phycfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_we,
    input  logic             bus_sel,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             pll_locked,
    input  logic             pll_out_en,
    output logic             sep_rate,
    output logic             ref_100m
);

    logic              wr_en;
    logic [HALF_W-1:0] cfg_q;
    cfg_cmd_t          cmd;
    logic              commit;
    logic [DATA_W-1:0] entry;

    assign wr_en = bus_valid & bus_we & (bus_sel == SEL_CMD);

    phycfg_maskreg u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wdata  (bus_wdata),
        .cfg_q  (cfg_q),
        .cmd    (cmd),
        .commit (commit)
    );

    phycfg_array #(
        .AW      (ADDR_W),
        .DW      (DATA_W),
        .TAP_A   (int'(CLKTEST_ADDR)),
        .TAP_B   (int'(SCC_ADDR)),
        .TAP_BIT (CTRL_BIT)
    ) u_arr (
        .clk   (clk),
        .rst   (rst),
        .we    (commit),
        .waddr (cmd.addr),
        .wdata (cmd.data),
        .raddr (cmd.addr),
        .rdata (entry),
        .tap_a (sep_rate),
        .tap_b (ref_100m)
    );

    phycfg_status u_stat (
        .sel        (bus_sel),
        .cfg_q      (cfg_q),
        .entry      (entry),
        .pll_locked (pll_locked),
        .pll_out_en (pll_out_en),
        .rdata      (bus_rdata)
    );

    AST_LOCK_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == SEL_STAT) |-> (bus_rdata[LOCK_BIT] == pll_locked
                                   && bus_rdata[PLLOUT_BIT] == pll_out_en)); // R7
    AST_CMD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel == SEL_CMD) |-> (bus_rdata[REG_W-1:HALF_W] == '0)); // R2

endmodule

// File: tb/phycfg_bridge_bench.sv
module phycfg_bridge_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pll_locked = 1'b0;
    logic        pll_out_en = 1'b0;
    logic        sep_rate;
    logic        ref_100m;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [15:0] m_cfg;
    logic [3:0]  m_mem [64];

    always #4 clk = ~clk;

    phycfg_bridge u_phycfg_bridge (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pll_locked(pll_locked), .pll_out_en(pll_out_en),
        .sep_rate(sep_rate), .ref_100m(ref_100m)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic sel, input logic we, input logic [31:0] w);
        logic [15:0] nv;
        @(negedge clk);
        bus_valid = 1'b1; bus_we = we; bus_sel = sel; bus_wdata = w;
        if (!sel && we) begin
            nv = (m_cfg & ~w[31:16]) | (w[15:0] & w[31:16]);
            if (nv[0] && !m_cfg[0]) m_mem[nv[6:1]] = nv[10:7];
            m_cfg = nv;
        end
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_we = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        @(posedge clk);
        @(negedge clk);
        bus_sel = sel; #1;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] exp_stat();
        logic [31:0] e;
        e = '0;
        e[3:0] = m_mem[m_cfg[6:1]];
        e[9]   = pll_locked;
        e[10]  = pll_out_en;
        return e;
    endfunction

    task automatic point(input logic [5:0] a);
        bus_wr(1'b0, 1'b1, {16'h007E, 9'd0, a, 1'b0});
    endtask

    task automatic check_entry(input string tag, input logic [5:0] a);
        logic [31:0] v;
        point(a);
        rd(1'b1, v);
        check(tag, v, exp_stat());
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] lf;
        m_cfg = '0;
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(1'b0, v); check("R1 cmd reg", v, 32'h0);
        check("R1 sep_rate", {31'd0, sep_rate}, 32'h0);
        check("R1 ref_100m", {31'd0, ref_100m}, 32'h0);
        for (int a = 0; a < 64; a += 9) check_entry("R1 entry", 6'(a));

        // R2 / R3 masked merge and field storage
        bus_wr(1'b0, 1'b1, 32'hFFFF_F800);
        rd(1'b0, v); check("R3 storage bits", v, {16'h0, m_cfg});
        bus_wr(1'b0, 1'b1, 32'h0000_FFFF);
        rd(1'b0, v); check("R2 mask zero keeps", v, {16'h0, m_cfg});
        bus_wr(1'b0, 1'b1, 32'hA5A4_0000);
        rd(1'b0, v); check("R2 partial mask", v, {16'h0, m_cfg});
        bus_wr(1'b0, 1'b1, 32'hFFFF_0000);

        // R4 exhaustive commit sweep: every address
        for (int a = 0; a < 64; a++) begin
            bus_wr(1'b0, 1'b1, {16'h07FE, 5'd0, 4'((a * 7 + 3) & 15), 6'(a), 1'b0});
            bus_wr(1'b0, 1'b1, 32'h0001_0001);
            bus_wr(1'b0, 1'b1, 32'h0001_0000);
        end
        for (int a = 0; a < 64; a++) check_entry("R4 R6 entry sweep", 6'(a));

        // R5 held-high strobe and masked-off strobe
        bus_wr(1'b0, 1'b1, {16'h07FF, 5'd0, 4'hC, 6'd20, 1'b1});
        bus_wr(1'b0, 1'b1, {16'h0781, 5'd0, 4'h5, 6'd0, 1'b1});
        check_entry("R5 held strobe", 6'd20);
        bus_wr(1'b0, 1'b1, 32'h0001_0000);
        bus_wr(1'b0, 1'b1, {16'h0780, 5'd0, 4'h6, 6'd0, 1'b1});
        check_entry("R5 strobe enable off", 6'd20);

        // R9 commit coinciding with next host write
        bus_wr(1'b0, 1'b1, 32'h0001_0000);
        bus_wr(1'b0, 1'b1, {16'h07FF, 5'd0, 4'h9, 6'd5, 1'b1});
        bus_wr(1'b0, 1'b1, {16'h07FF, 5'd0, 4'h3, 6'd6, 1'b0});
        check_entry("R9 first addr", 6'd5);
        check_entry("R9 second addr", 6'd6);

        // R10 ignored accesses
        bus_wr(1'b0, 1'b0, {16'h07FF, 5'd0, 4'hF, 6'd7, 1'b1});
        rd(1'b0, v); check("R10 read-cycle cmd", v, {16'h0, m_cfg});
        bus_wr(1'b1, 1'b1, {16'h07FF, 5'd0, 4'hF, 6'd7, 1'b1});
        rd(1'b0, v); check("R10 status write cmd", v, {16'h0, m_cfg});
        check_entry("R10 entry untouched", 6'd7);

        // R7 PLL indications, all combinations
        for (int p = 0; p < 4; p++) begin
            pll_locked = p[0]; pll_out_en = p[1];
            rd(1'b1, v); check("R7 R6 pll bits", v, exp_stat());
        end

        // R8 control taps
        bus_wr(1'b0, 1'b1, 32'h0001_0000);
        bus_wr(1'b0, 1'b1, {16'h07FF, 5'd0, 4'h8, 6'h10, 1'b1});
        bus_wr(1'b0, 1'b1, 32'h0001_0000);
        bus_wr(1'b0, 1'b1, {16'h07FF, 5'd0, 4'h7, 6'h12, 1'b1});
        @(posedge clk); @(negedge clk);
        check("R8 sep_rate set", {31'd0, sep_rate}, 32'h1);
        check("R8 ref_100m clear", {31'd0, ref_100m}, 32'h0);
        bus_wr(1'b0, 1'b1, 32'h0001_0000);
        bus_wr(1'b0, 1'b1, {16'h07FF, 5'd0, 4'hF, 6'h12, 1'b1});
        @(posedge clk); @(negedge clk);
        check("R8 ref_100m set", {31'd0, ref_100m}, 32'h1);

        // R2 R4 pseudo-random masked write sweep
        lf = 32'h1ACE_B00C;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            bus_wr(1'b0, 1'b1, lf);
            if (k % 8 == 0) begin
                rd(1'b0, v); check("R2 random merge", v, {16'h0, m_cfg});
            end
        end
        for (int a = 0; a < 64; a++) check_entry("R4 random sweep", 6'(a));
        @(negedge clk);
        check("R8 sep_rate model", {31'd0, sep_rate}, {31'd0, m_mem[16][3]});
        check("R8 ref_100m model", {31'd0, ref_100m}, {31'd0, m_mem[18][3]});

        // R1 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        m_cfg = '0;
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        rd(1'b0, v); check("R1 cmd after reset", v, 32'h0);
        for (int a = 0; a < 64; a += 5) check_entry("R1 entry after reset", 6'(a));

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule